// File: doc/BRIEF.md
# Bus Address Watchpoint Unit

The unit watches the request stream of a shared memory bus. Several bus clients issue requests, and it raises a debug interrupt when one of them touches a guarded address range with a guarded kind of access. It holds four independent watchpoints. Each one has an inclusive address window, a mask of operation kinds and a mask of clients. A request that satisfies all three in a watchpoint is a hit.

On its first hit a watchpoint records the offending access: the address, the operation, the first client that hit and the access size. It also keeps a client set, which gathers every client that hits while the record is held. The record stays frozen until software clears it with a write to that watchpoint's own acknowledge register. Each new record also sets a per-watchpoint pending bit in a global interrupt block. That block has an enable mask, a masked-status view and a write-one-to-clear acknowledge. The interrupt line is the OR of the masked pending bits.

The request side is a valid/ready stream that the unit only observes. A request counts when `req_valid` and `req_ready` are both high on a rising clock edge. The unit never drives `req_ready`, so it never applies back-pressure to the bus. A stalled request (valid without ready) is not observed, and it is seen only in the cycle in which it is accepted. The register port is a plain single-cycle write strobe with a combinational read. The unit does not block or alter any access.

Top module: `bus_watch_unit`

## Requirements
- R1: After reset every register reads as zero: windows, masks, captures, pending bits and the interrupt enable mask. `irq` is low.
- R2: A watchpoint hits on a clock edge where `req_valid` and `req_ready` are both 1, `first <= req_addr <= last` (unsigned, inclusive at both ends), bit `req_op` of its operation mask is set and bit `req_client` of its client mask is set. A request with `req_ready` low has no effect.
- R3: Operation codes are 0 read, 1 write, 2 atomic and 3 prefetch. Operation mask bit k enables code k, so the value 2 selects writes only. An all-ones client mask selects every client.
- R4: A hit on a watchpoint that holds no record makes it hold one. From the next cycle the record reads back the address, the operation, the first client, the size and a client set with only that client's bit.
- R5: While a record is held, further hits leave the address, operation, first client and size unchanged. They OR their client bit into the client set.
- R6: A write of any data to a watchpoint's local-acknowledge register drops its record and clears the client set from the next cycle. A hit in that same cycle is ignored.
- R7: Each new record sets that watchpoint's pending bit. Further hits on a held record do not set it. A global-acknowledge write clears the pending bits whose data bits are 1. A new record in the same cycle keeps its bit set.
- R8: The masked status equals pending AND the enable mask, and `irq` is high exactly when the masked status is non-zero. `irq` first rises in the cycle after the hit edge.
- R9: The watchpoints are independent. One request may hit and be recorded by several of them, and a request outside a watchpoint's criteria leaves that watchpoint unchanged.
- R10: Register words (with n = watchpoint 0..3) are:
  - 8n+0: first address.
  - 8n+1: last address.
  - 8n+2: operation mask, in bits 3:0.
  - 8n+3: client mask.
  - 8n+4: client set (read only).
  - 8n+5: captured address (read only).
  - 8n+6: captured info (read only). Bits 1:0 hold the operation, 5:2 the first client, 8:6 the size, and bit 31 is the held flag.
  - 8n+7: local acknowledge (write only, reads zero).
  - 32: interrupt enable mask.
  - 33: raw pending.
  - 34: masked status.
  - 35: global acknowledge (reads zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | input | 1 | Bus request ready (observed only) |
| req_addr | input | ADDR_W | Request address |
| req_op | input | 2 | Operation code |
| req_client | input | CLI_W | Requesting client index |
| req_size | input | SIZE_W | Access size code |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt, OR of masked pending bits |

## Verification
The bound checker watches the following on every cycle:
- A held address stays put until it is acknowledged.
- A local acknowledge always drops the record.
- A record or pending bit only appears after an accepted transfer.
- A pending bit never rises without a new record.
- `irq` is quiet while the enable mask is zero.

The directed scenarios cover the rest, measured against a reference model of the register file. That means the window edges, operation and client selection, the content of each captured field, the growth of the client set, the two-step acknowledge, same-cycle priorities and hits on overlapping watchpoints.

// File: rtl/bwu_pkg.sv
package bwu_pkg;
  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_ATOMIC   = 2'd2,
    OP_PREFETCH = 2'd3
  } bus_op_e;

  localparam int unsigned OP_KINDS = 4;

  // per-watchpoint register words (low three address bits)
  localparam logic [2:0] FLD_FIRST = 3'd0;
  localparam logic [2:0] FLD_LAST  = 3'd1;
  localparam logic [2:0] FLD_OPS   = 3'd2;
  localparam logic [2:0] FLD_CLI   = 3'd3;
  localparam logic [2:0] FLD_CSET  = 3'd4;
  localparam logic [2:0] FLD_CADDR = 3'd5;
  localparam logic [2:0] FLD_CINFO = 3'd6;
  localparam logic [2:0] FLD_LACK  = 3'd7;

  // global register words (low two address bits)
  localparam logic [1:0] GLB_MASK  = 2'd0;
  localparam logic [1:0] GLB_RAW   = 2'd1;
  localparam logic [1:0] GLB_MSKD  = 2'd2;
  localparam logic [1:0] GLB_ACK   = 2'd3;
endpackage

// File: rtl/bwu_match.sv
module bwu_match
  import bwu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NCLI   = 16,
  parameter int unsigned CLI_W  = 4
) (
  input  logic                xfer,
  input  logic [ADDR_W-1:0]   addr,
  input  bus_op_e             op,
  input  logic [CLI_W-1:0]    client,
  input  logic [ADDR_W-1:0]   win_first,
  input  logic [ADDR_W-1:0]   win_last,
  input  logic [OP_KINDS-1:0] op_sel,
  input  logic [NCLI-1:0]     cli_sel,
  output logic                hit
);
  logic in_window;
  logic op_ok;
  logic cli_ok;

  assign in_window = (addr >= win_first) && (addr <= win_last);
  assign op_ok     = op_sel[op];
  assign cli_ok    = cli_sel[client];
  assign hit       = xfer && in_window && op_ok && cli_ok;
endmodule

// File: rtl/bwu_slot.sv
module bwu_slot
  import bwu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NCLI   = 16,
  parameter int unsigned CLI_W  = 4,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_fld,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                loc_ack,
  input  logic                xfer,
  input  logic [ADDR_W-1:0]   req_addr,
  input  bus_op_e             req_op,
  input  logic [CLI_W-1:0]    req_client,
  input  logic [SIZE_W-1:0]   req_size,
  output logic [ADDR_W-1:0]   win_first,
  output logic [ADDR_W-1:0]   win_last,
  output logic [OP_KINDS-1:0] op_sel,
  output logic [NCLI-1:0]     cli_sel,
  output logic [NCLI-1:0]     cap_set,
  output logic [ADDR_W-1:0]   cap_addr,
  output bus_op_e             cap_op,
  output logic [CLI_W-1:0]    cap_first,
  output logic [SIZE_W-1:0]   cap_size,
  output logic                holding,
  output logic                new_cap
);
  logic            hit;
  logic [NCLI-1:0] cli_bit;

  bwu_match #(.ADDR_W(ADDR_W), .NCLI(NCLI), .CLI_W(CLI_W)) u_match (
    .xfer      (xfer),
    .addr      (req_addr),
    .op        (req_op),
    .client    (req_client),
    .win_first (win_first),
    .win_last  (win_last),
    .op_sel    (op_sel),
    .cli_sel   (cli_sel),
    .hit       (hit)
  );

  assign cli_bit = NCLI'(1) << req_client;
  assign new_cap = hit && !holding && !loc_ack;

  // programming words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_first <= '0;
      win_last  <= '0;
      op_sel    <= '0;
      cli_sel   <= '0;
    end else if (cfg_we) begin
      case (cfg_fld)
        FLD_FIRST: win_first <= cfg_wdata[ADDR_W-1:0];
        FLD_LAST:  win_last  <= cfg_wdata[ADDR_W-1:0];
        FLD_OPS:   op_sel    <= cfg_wdata[OP_KINDS-1:0];
        FLD_CLI:   cli_sel   <= cfg_wdata[NCLI-1:0];
        default: ;
      endcase
    end
  end

  // capture record: acknowledge beats a hit, first hit freezes the record
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holding   <= 1'b0;
      cap_set   <= '0;
      cap_addr  <= '0;
      cap_op    <= OP_READ;
      cap_first <= '0;
      cap_size  <= '0;
    end else if (loc_ack) begin
      holding   <= 1'b0;
      cap_set   <= '0;
    end else if (hit) begin
      if (!holding) begin
        holding   <= 1'b1;
        cap_set   <= cli_bit;
        cap_addr  <= req_addr;
        cap_op    <= req_op;
        cap_first <= req_client;
        cap_size  <= req_size;
      end else begin
        cap_set   <= cap_set | cli_bit;
      end
    end
  end
endmodule

// File: rtl/bwu_irq.sv
module bwu_irq #(
  parameter int unsigned NWP    = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWP-1:0]    new_cap,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [NWP-1:0]    enable,
  output logic [NWP-1:0]    pending,
  output logic [NWP-1:0]    masked,
  output logic              irq
);
  logic [NWP-1:0] clr;

  assign clr = ack_we ? wdata[NWP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable  <= '0;
      pending <= '0;
    end else begin
      if (mask_we) enable <= wdata[NWP-1:0];
      pending <= (pending & ~clr) | new_cap;
    end
  end

  assign masked = pending & enable;
  assign irq    = |masked;
endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
  import bwu_pkg::*;
#(
  parameter int unsigned NWP    = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NCLI   = 16,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CLI_W = $clog2(NCLI),
  localparam int unsigned WP_W  = $clog2(NWP),
  localparam int unsigned REG_AW = WP_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [CLI_W-1:0]  req_client,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic            xfer;
  bus_op_e         op_in;
  logic            is_glb;
  logic [WP_W-1:0] wp_sel;
  logic [2:0]      fld;

  logic [NWP-1:0]  slot_we;
  logic [NWP-1:0]  loc_ack;
  logic [NWP-1:0]  holding;
  logic [NWP-1:0]  new_cap;
  logic [NWP-1:0]  enable;
  logic [NWP-1:0]  pending;
  logic [NWP-1:0]  masked;
  logic [NWP*ADDR_W-1:0] cap_addr_v;

  logic [ADDR_W-1:0]   win_first [NWP];
  logic [ADDR_W-1:0]   win_last  [NWP];
  logic [OP_KINDS-1:0] op_sel    [NWP];
  logic [NCLI-1:0]     cli_sel   [NWP];
  logic [NCLI-1:0]     cap_set   [NWP];
  logic [ADDR_W-1:0]   cap_addr  [NWP];
  bus_op_e             cap_op    [NWP];
  logic [CLI_W-1:0]    cap_first [NWP];
  logic [SIZE_W-1:0]   cap_size  [NWP];

  assign xfer   = req_valid && req_ready;
  assign op_in  = bus_op_e'(req_op);
  assign is_glb = reg_addr[REG_AW-1];
  assign wp_sel = reg_addr[3 +: WP_W];
  assign fld    = reg_addr[2:0];

  for (genvar i = 0; i < NWP; i++) begin : g_wp
    assign slot_we[i] = reg_wen && !is_glb && (wp_sel == WP_W'(i));
    assign loc_ack[i] = slot_we[i] && (fld == FLD_LACK);
    assign cap_addr_v[i*ADDR_W +: ADDR_W] = cap_addr[i];

    bwu_slot #(
      .ADDR_W(ADDR_W), .NCLI(NCLI), .CLI_W(CLI_W),
      .SIZE_W(SIZE_W), .DATA_W(DATA_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (slot_we[i]),
      .cfg_fld    (fld),
      .cfg_wdata  (reg_wdata),
      .loc_ack    (loc_ack[i]),
      .xfer       (xfer),
      .req_addr   (req_addr),
      .req_op     (op_in),
      .req_client (req_client),
      .req_size   (req_size),
      .win_first  (win_first[i]),
      .win_last   (win_last[i]),
      .op_sel     (op_sel[i]),
      .cli_sel    (cli_sel[i]),
      .cap_set    (cap_set[i]),
      .cap_addr   (cap_addr[i]),
      .cap_op     (cap_op[i]),
      .cap_first  (cap_first[i]),
      .cap_size   (cap_size[i]),
      .holding    (holding[i]),
      .new_cap    (new_cap[i])
    );
  end

  bwu_irq #(.NWP(NWP), .DATA_W(DATA_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .new_cap (new_cap),
    .mask_we (reg_wen && is_glb && (fld[1:0] == GLB_MASK)),
    .ack_we  (reg_wen && is_glb && (fld[1:0] == GLB_ACK)),
    .wdata   (reg_wdata),
    .enable  (enable),
    .pending (pending),
    .masked  (masked),
    .irq     (irq)
  );

  // combinational read-back
  always_comb begin
    reg_rdata = '0;
    if (is_glb) begin
      case (fld[1:0])
        GLB_MASK: reg_rdata = DATA_W'(enable);
        GLB_RAW:  reg_rdata = DATA_W'(pending);
        GLB_MSKD: reg_rdata = DATA_W'(masked);
        default:  reg_rdata = '0;
      endcase
    end else begin
      case (fld)
        FLD_FIRST: reg_rdata = DATA_W'(win_first[wp_sel]);
        FLD_LAST:  reg_rdata = DATA_W'(win_last[wp_sel]);
        FLD_OPS:   reg_rdata = DATA_W'(op_sel[wp_sel]);
        FLD_CLI:   reg_rdata = DATA_W'(cli_sel[wp_sel]);
        FLD_CSET:  reg_rdata = DATA_W'(cap_set[wp_sel]);
        FLD_CADDR: reg_rdata = DATA_W'(cap_addr[wp_sel]);
        FLD_CINFO: begin
          reg_rdata[1:0]               = cap_op[wp_sel];
          reg_rdata[2 +: CLI_W]        = cap_first[wp_sel];
          reg_rdata[2+CLI_W +: SIZE_W] = cap_size[wp_sel];
          reg_rdata[DATA_W-1]          = holding[wp_sel];
        end
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bwu_checker.sv
module bwu_checker #(
  parameter int unsigned NWP    = 4,
  parameter int unsigned ADDR_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xfer,
  input logic [NWP-1:0]        holding,
  input logic [NWP-1:0]        pending,
  input logic [NWP-1:0]        enable,
  input logic [NWP-1:0]        loc_ack,
  input logic [NWP*ADDR_W-1:0] cap_addr_v,
  input logic                  irq
);
  for (genvar i = 0; i < NWP; i++) begin : g_chk
    // R5: held address does not move until acknowledged
    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (holding[i] && !loc_ack[i]) |=> $stable(cap_addr_v[i*ADDR_W +: ADDR_W]));

    // R6: local acknowledge always drops the record
    a_r6_local_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      loc_ack[i] |=> !holding[i]);

    // R2: a record only appears after an accepted transfer
    a_r2_record_needs_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> !$rose(holding[i]));

    // R7: a pending bit rises only together with a new record
    a_r7_pend_with_record: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending[i]) |-> $rose(holding[i]));
  end

  // R8: no interrupt while every enable bit is clear
  a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
endmodule

bind bus_watch_unit bwu_checker #(.NWP(NWP), .ADDR_W(ADDR_W)) u_bwu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer       (xfer),
  .holding    (holding),
  .pending    (pending),
  .enable     (enable),
  .loc_ack    (loc_ack),
  .cap_addr_v (cap_addr_v),
  .irq        (irq)
);

// File: tb/sim_bus_watch_unit.sv
`timescale 1ns/100ps
module sim_bus_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [3:0]  req_client = '0;
  logic [2:0]  req_size = '0;
  logic        reg_wen = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_watch_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_client(req_client),
    .req_size(req_size), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // reference model of the register file
  logic [31:0] m_first[4], m_last[4], m_caddr[4];
  logic [3:0]  m_ops[4];
  logic [15:0] m_cli[4], m_set[4];
  logic [1:0]  m_op[4];
  logic [3:0]  m_fc[4];
  logic [2:0]  m_sz[4];
  logic        m_hold[4];
  logic [3:0]  m_pend, m_en;

  function automatic logic [5:0] ra(int wp, int f);
    return 6'(wp*8 + f);
  endfunction
  function automatic logic [5:0] ga(int f);
    return 6'(32 + f);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_first[i] = 0; m_last[i] = 0; m_caddr[i] = 0; m_ops[i] = 0; m_cli[i] = 0;
      m_set[i] = 0; m_op[i] = 0; m_fc[i] = 0; m_sz[i] = 0; m_hold[i] = 0;
    end
    m_pend = 0; m_en = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // one clock: optional request and optional register write in the same cycle
  task automatic step(bit rq, bit rdy, logic [31:0] a, logic [1:0] op, logic [3:0] c,
                      logic [2:0] sz, bit we, logic [5:0] wa, logic [31:0] wd);
    logic [3:0] hits, newc;
    @(negedge clk);
    req_valid = rq; req_ready = rdy; req_addr = a; req_op = op; req_client = c; req_size = sz;
    reg_wen = we; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    hits = 0; newc = 0;
    for (int i = 0; i < 4; i++)
      hits[i] = rq && rdy && (a >= m_first[i]) && (a <= m_last[i]) && m_ops[i][op] && m_cli[i][c];
    for (int i = 0; i < 4; i++) begin
      if (we && !wa[5] && wa[4:3] == 2'(i) && wa[2:0] == 3'd7) begin
        m_hold[i] = 0; m_set[i] = 0;
      end else if (hits[i]) begin
        if (!m_hold[i]) begin
          newc[i] = 1; m_hold[i] = 1; m_set[i] = 16'(1) << c;
          m_caddr[i] = a; m_op[i] = op; m_fc[i] = c; m_sz[i] = sz;
        end else m_set[i] = m_set[i] | (16'(1) << c);
      end
      if (we && !wa[5] && wa[4:3] == 2'(i)) begin
        case (wa[2:0])
          3'd0: m_first[i] = wd;
          3'd1: m_last[i] = wd;
          3'd2: m_ops[i] = wd[3:0];
          3'd3: m_cli[i] = wd[15:0];
          default: ;
        endcase
      end
    end
    m_pend = (m_pend & ~((we && wa[5] && wa[1:0] == 2'd3) ? wd[3:0] : 4'd0)) | newc;
    if (we && wa[5] && wa[1:0] == 2'd0) m_en = wd[3:0];
    #1;
    req_valid = 0; req_ready = 0; reg_wen = 0;
  endtask

  task automatic wr(logic [5:0] wa, logic [31:0] wd);
    step(0, 0, 0, 0, 0, 0, 1, wa, wd);
  endtask
  task automatic req(logic [31:0] a, logic [1:0] op, logic [3:0] c, logic [2:0] sz);
    step(1, 1, a, op, c, sz, 0, 0, 0);
  endtask

  task automatic chk_all(string tag);
    logic [31:0] d, e;
    for (int i = 0; i < 4; i++) begin
      rd(ra(i, 0), d); chk(tag, d, m_first[i]);
      rd(ra(i, 1), d); chk(tag, d, m_last[i]);
      rd(ra(i, 2), d); chk(tag, d, 32'(m_ops[i]));
      rd(ra(i, 3), d); chk(tag, d, 32'(m_cli[i]));
      rd(ra(i, 4), d); chk(tag, d, 32'(m_set[i]));
      rd(ra(i, 5), d); chk(tag, d, m_caddr[i]);
      e = 0; e[1:0] = m_op[i]; e[5:2] = m_fc[i]; e[8:6] = m_sz[i]; e[31] = m_hold[i];
      rd(ra(i, 6), d); chk(tag, d, e);
      rd(ra(i, 7), d); chk(tag, d, 0);
    end
    rd(ga(0), d); chk(tag, d, 32'(m_en));
    rd(ga(1), d); chk(tag, d, 32'(m_pend));
    rd(ga(2), d); chk(tag, d, 32'(m_pend & m_en));
    rd(ga(3), d); chk(tag, d, 0);
    chk(tag, 32'(irq), 32'(|(m_pend & m_en)));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_all("R1");
    rd(ga(1), d); chk("R1 pending", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(ra(0, 0), 32'h1000); wr(ra(0, 1), 32'h10FF);
    wr(ra(0, 2), 32'h2); wr(ra(0, 3), 32'hFFFF); wr(ga(0), 32'hF);
    rd(ra(0, 1), d); chk("R10 last readback", d, 32'h10FF);
    req(32'h0FFF, 2'd1, 4'd3, 3'd2);         // below window
    req(32'h1100, 2'd1, 4'd3, 3'd2);         // above window
    req(32'h1000, 2'd0, 4'd3, 3'd2);         // read, not selected
    step(1, 0, 32'h1000, 2'd1, 4'd3, 3'd2, 0, 0, 0); // stalled
    rd(ra(0, 6), d); chk("R2 no record yet", d, 0);
    chk("R3 no irq", 32'(irq), 0);
    chk_all("R2");
  endtask

  task automatic t_capture();
    logic [31:0] d;
    req(32'h10FF, 2'd1, 4'd5, 3'd2);         // top edge, write
    rd(ra(0, 5), d); chk("R4 addr", d, 32'h10FF);
    rd(ra(0, 6), d); chk("R4 info", d, 32'h8000_0095);
    rd(ra(0, 4), d); chk("R4 client set", d, 32'h20);
    chk("R8 irq", 32'(irq), 1);
    chk_all("R4");
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    req(32'h1010, 2'd1, 4'd9, 3'd1);
    req(32'h1000, 2'd1, 4'd5, 3'd0);
    rd(ra(0, 5), d); chk("R5 addr frozen", d, 32'h10FF);
    rd(ra(0, 4), d); chk("R5 set grows", d, 32'h220);
    chk_all("R5");
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(ga(0), 32'hE);
    chk("R8 masked irq", 32'(irq), 0);
    rd(ga(2), d); chk("R8 masked status", d, 0);
    rd(ga(1), d); chk("R8 raw kept", d, 1);
    wr(ga(0), 32'hF);
    chk("R8 irq back", 32'(irq), 1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(ga(3), 32'h1);
    rd(ga(1), d); chk("R7 global ack", d, 0);
    rd(ra(0, 6), d); chk("R7 record still held", 32'(d[31]), 1);
    req(32'h1020, 2'd1, 4'd1, 3'd3);
    rd(ga(1), d); chk("R7 no new pending", d, 0);
    wr(ra(0, 7), 32'h0);
    rd(ra(0, 6), d); chk("R6 dropped", 32'(d[31]), 0);
    rd(ra(0, 4), d); chk("R6 set cleared", d, 0);
    req(32'h1030, 2'd1, 4'd7, 3'd4);
    rd(ra(0, 5), d); chk("R6 new record", d, 32'h1030);
    rd(ga(1), d); chk("R7 pending again", d, 1);
    chk_all("R6");
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    step(1, 1, 32'h1040, 2'd1, 4'd2, 3'd1, 1, ra(0, 7), 0);
    rd(ra(0, 6), d); chk("R6 ack beats hit", 32'(d[31]), 0);
    step(1, 1, 32'h1050, 2'd1, 4'd2, 3'd1, 1, ga(3), 32'h1);
    rd(ga(1), d); chk("R7 set beats clear", d, 1);
    rd(ra(0, 5), d); chk("R7 record addr", d, 32'h1050);
    chk_all("R7");
  endtask

  task automatic t_multi();
    logic [31:0] d;
    wr(ra(1, 0), 32'h2000); wr(ra(1, 1), 32'h2FFF); wr(ra(1, 2), 32'hF); wr(ra(1, 3), 32'h0010);
    wr(ra(2, 0), 32'h2800); wr(ra(2, 1), 32'h3000); wr(ra(2, 2), 32'h4); wr(ra(2, 3), 32'hFFFF);
    wr(ra(3, 0), 32'h2800); wr(ra(3, 1), 32'h3000); wr(ra(3, 2), 32'h4); wr(ra(3, 3), 32'h0001);
    req(32'h2900, 2'd2, 4'd4, 3'd5);
    rd(ga(1), d); chk("R9 both hit", d & 32'hE, 32'h6);
    rd(ra(3, 6), d); chk("R9 wp3 untouched", 32'(d[31]), 0);
    chk_all("R9");
  endtask

  task automatic t_random();
    for (int n = 0; n < 600; n++) begin
      int k;
      logic [5:0] wa;
      logic [31:0] wd;
      bit we;
      if (n % 150 == 0) begin
        for (int i = 0; i < 4; i++) begin
          logic [31:0] lo;
          lo = 32'($urandom_range(0, 200));
          wr(ra(i, 0), lo);
          wr(ra(i, 1), lo + 32'($urandom_range(0, 60)));
          wr(ra(i, 2), 32'($urandom_range(1, 15)));
          wr(ra(i, 3), 32'($urandom));
        end
        wr(ga(0), 32'($urandom_range(0, 15)));
      end
      k = $urandom_range(0, 9);
      we = (k < 2);
      wa = (k == 0) ? ra($urandom_range(0, 3), 7) : ga(3);
      wd = 32'($urandom_range(0, 15));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
           32'($urandom_range(0, 280)), 2'($urandom), 4'($urandom),
           3'($urandom), we, wa, wd);
      if (n % 10 == 0) chk_all("R2 random");
    end
    chk_all("R3 random end");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_window();
    t_capture();
    t_freeze();
    t_mask();
    t_ack();
    t_same_cycle();
    t_multi();
    t_random();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule